// File: doc/BRIEF.md
# Line Voltage Sag Detector

This block monitors the sample stream of the voltage channel and flags a sustained drop in line voltage. Each valid signed sample is reduced to a magnitude byte: the absolute value is doubled and its upper eight bits are kept. A sample is classed as low when the programmed sag level is larger than that byte. A separate strobe marks the end of every half line cycle. A half cycle is counted as sagged only if none of its samples reached the level.

When the number of consecutive sagged half cycles reaches the programmed cycle count, the detector enters the sag state. It drives an active-low sag output and sends a single-cycle event to the status logic. The first sample that reaches the level again ends the sag state and clears the count. A disable input holds the output pin inactive but has no effect on the event. The surrounding register file supplies the level, the cycle count and the disable bit as plain ports. After reset it holds a level of 0x00 and a count of 0xFF.

Top module: `sag_detector`

## Requirements
- R1: The magnitude byte is bits [18:11] of |sample|, which equals the top byte of the 20-bit value |sample| shifted left by one. Samples are 20-bit two's complement. A positive or negative full-scale peak of 0x257F6 gives 0x4A.
- R2: The most negative sample 0x80000, whose magnitude does not fit in 19 bits, saturates the magnitude byte to 0xFF.
- R3: A valid sample is low when sag_level_i > magnitude byte; otherwise it is high. A level of 0x00 never produces a low sample, so detection never triggers.
- R4: The half cycle that a half_cycle_i strobe closes counts as sagged only if no high sample arrived during it. A sample in the same cycle as the strobe belongs to the half cycle being closed.
- R5: sag_n_o goes low at the clock edge that samples the strobe closing the Nth consecutive sagged half cycle, where N is sag_cycles_i, when sag_disable_i is 0.
- R6: A sag_cycles_i value of 0 behaves as 1.
- R7: A high sample clears the half-cycle count and ends the sag state at the next clock edge. sag_n_o is then high.
- R8: While sag_disable_i is 1, sag_n_o is held high. When sag_disable_i is cleared during an active sag, sag_n_o goes low in the same cycle. sag_event_o is unaffected by sag_disable_i.
- R9: sag_event_o pulses high for exactly one cycle on entry to the sag state. It does not pulse again while the sag persists.
- R10: The half-cycle count saturates at 255 and never wraps, so N = 255 asserts after exactly 255 sagged half cycles.
- R11: While and after rst_ni is low, sag_n_o is high, sag_event_o is low and the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | sample_i carries a new sample this cycle |
| sample_i | input | 20 | Voltage-channel sample, two's complement |
| half_cycle_i | input | 1 | Strobe closing the current half line cycle |
| sag_level_i | input | 8 | Sag threshold compared with the magnitude byte |
| sag_cycles_i | input | 8 | Consecutive sagged half cycles needed to assert |
| sag_disable_i | input | 1 | 1 keeps the sag output inactive |
| sag_n_o | output | 1 | Sag indication, active low |
| sag_event_o | output | 1 | One-cycle pulse on entry to the sag state |

## Verification
The bench builds the detector with its default widths: 20-bit samples, an 8-bit level and an 8-bit half-cycle counter. With these widths the real full-scale code 0x257F6 and the most negative code 0x80000 can be driven directly. The counter ceiling of 255 can be reached in a few hundred clock cycles, so a cycle count of 255 and the saturation point are both exercised. A table of sample and level pairs covers the threshold rule at N = 1. Directed sequences cover multi-half-cycle counting, release, mixed halves, the disable path and reset during an active sag.

// File: rtl/sag_pkg.sv
package sag_pkg;
  localparam int unsigned SAMPLE_W = 20;  // voltage sample width
  localparam int unsigned LVL_W    = 8;   // threshold / magnitude byte width
  localparam int unsigned CNT_W    = 8;   // half-cycle counter and cycle-count width
endpackage

// File: rtl/sag_mag_cmp.sv
module sag_mag_cmp #(
  parameter int unsigned SAMPLE_W = sag_pkg::SAMPLE_W,
  parameter int unsigned LVL_W    = sag_pkg::LVL_W
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                valid_i,
  input  logic [LVL_W-1:0]    level_i,
  output logic                above_o
);
  localparam int unsigned TOP = SAMPLE_W - 2;  // MSB of |x| after the 1-bit left shift
  localparam logic [SAMPLE_W-1:0] ONE = {{(SAMPLE_W-1){1'b0}}, 1'b1};

  logic [SAMPLE_W-1:0] mag;
  logic [LVL_W-1:0]    mag_byte;

  always_comb begin
    if (sample_i[SAMPLE_W-1]) mag = ~sample_i + ONE;
    else                      mag = sample_i;
  end

  // only the most negative code sets the magnitude MSB: saturate it
  assign mag_byte = mag[SAMPLE_W-1] ? {LVL_W{1'b1}} : mag[TOP -: LVL_W];
  assign above_o  = valid_i & (mag_byte >= level_i);
endmodule

// File: rtl/sag_hc_cnt.sv
module sag_hc_cnt #(
  parameter int unsigned CNT_W = sag_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             above_i,
  input  logic             boundary_i,
  output logic             credit_o,
  output logic [CNT_W-1:0] cnt_inc_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             dirty_q;
  logic [CNT_W-1:0] cnt_q;

  // closing half is clean if nothing high arrived in it, this cycle included
  assign credit_o  = boundary_i & ~dirty_q & ~above_i;
  assign cnt_inc_o = (cnt_q == {CNT_W{1'b1}}) ? cnt_q : cnt_q + ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dirty_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (boundary_i)   dirty_q <= 1'b0;
      else if (above_i) dirty_q <= 1'b1;
      if (above_i)       cnt_q <= '0;
      else if (credit_o) cnt_q <= cnt_inc_o;
    end
  end

  assert_cnt_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + ONE));
  assert_cnt_no_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_q) == {CNT_W{1'b1}} && !$past(above_i)) |-> (cnt_q == {CNT_W{1'b1}}));
  assert_cnt_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    above_i |=> (cnt_q == '0));
endmodule

// File: rtl/sag_out_ctl.sv
module sag_out_ctl #(
  parameter int unsigned CNT_W = sag_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             credit_i,
  input  logic [CNT_W-1:0] cnt_inc_i,
  input  logic [CNT_W-1:0] cycles_i,
  input  logic             above_i,
  input  logic             disable_i,
  output logic             sag_n_o,
  output logic             event_o
);
  logic [CNT_W-1:0] n_eff;
  logic             hit;
  logic             sag_q;
  logic             event_q;

  assign n_eff = (cycles_i == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : cycles_i;
  assign hit   = credit_i & (cnt_inc_i >= n_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sag_q   <= 1'b0;
      event_q <= 1'b0;
    end else begin
      if (above_i)  sag_q <= 1'b0;
      else if (hit) sag_q <= 1'b1;
      event_q <= hit & ~sag_q;
    end
  end

  assign sag_n_o = ~(sag_q & ~disable_i);
  assign event_o = event_q;

  assert_event_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_q |=> !event_q);
endmodule

// File: rtl/sag_detector.sv
module sag_detector #(
  parameter int unsigned SAMPLE_W = sag_pkg::SAMPLE_W,
  parameter int unsigned LVL_W    = sag_pkg::LVL_W,
  parameter int unsigned CNT_W    = sag_pkg::CNT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                half_cycle_i,
  input  logic [LVL_W-1:0]    sag_level_i,
  input  logic [CNT_W-1:0]    sag_cycles_i,
  input  logic                sag_disable_i,
  output logic                sag_n_o,
  output logic                sag_event_o
);
  logic             above;
  logic             credit;
  logic [CNT_W-1:0] cnt_inc;

  sag_mag_cmp #(.SAMPLE_W(SAMPLE_W), .LVL_W(LVL_W)) u_cmp (
    .sample_i (sample_i),
    .valid_i  (sample_valid_i),
    .level_i  (sag_level_i),
    .above_o  (above)
  );

  sag_hc_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .above_i    (above),
    .boundary_i (half_cycle_i),
    .credit_o   (credit),
    .cnt_inc_o  (cnt_inc)
  );

  sag_out_ctl #(.CNT_W(CNT_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .credit_i  (credit),
    .cnt_inc_i (cnt_inc),
    .cycles_i  (sag_cycles_i),
    .above_i   (above),
    .disable_i (sag_disable_i),
    .sag_n_o   (sag_n_o),
    .event_o   (sag_event_o)
  );

  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    above |=> sag_n_o);
  assert_level_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && sag_level_i == '0) |-> above);
  assert_disable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sag_disable_i |-> sag_n_o);
  assert_event_drives_pin_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sag_event_o && !sag_disable_i) |-> !sag_n_o);
endmodule

// File: tb/sag_detector_tb.sv
`timescale 1ns/1ps
module sag_detector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [19:0] sample = '0;
  logic        hc = 1'b0;
  logic [7:0]  level = 8'h00;
  logic [7:0]  cycles = 8'hFF;
  logic        dis = 1'b0;
  logic        sag_n;
  logic        evt;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  sag_detector u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(valid), .sample_i(sample),
    .half_cycle_i(hc), .sag_level_i(level), .sag_cycles_i(cycles),
    .sag_disable_i(dis), .sag_n_o(sag_n), .sag_event_o(evt)
  );

  // {sample, level, expect_sag} at N = 1
  localparam logic [28:0] VECS [0:10] = '{
    {20'h257F6, 8'h4A, 1'b0},  // R1 full scale byte 0x4A
    {20'h257F6, 8'h4B, 1'b1},  // R1 R3
    {20'hDA80A, 8'h4B, 1'b1},  // R1 negative full scale
    {20'hDA80A, 8'h4A, 1'b0},  // R1
    {20'h80000, 8'hFF, 1'b0},  // R2 saturation
    {20'h00000, 8'h00, 1'b0},  // R3 level zero
    {20'h00000, 8'h01, 1'b1},  // R3
    {20'h007FF, 8'h01, 1'b1},  // R1 bit 11 clear
    {20'h00800, 8'h01, 1'b0},  // R1 bit 11 set
    {20'h7FFFF, 8'hFF, 1'b0},  // R1 max positive
    {20'hFFFFF, 8'h01, 1'b1}   // R1 minus one
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic tick(input logic v, input logic [19:0] s, input logic b);
    valid = v; sample = s; hc = b;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0; hc = 1'b0;
  endtask

  task automatic clean_start();
    tick(1'b1, 20'h7FFFF, 1'b1);  // high sample closes a half, next half starts clean
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset sag_n", sag_n, 1);
    chk("R11 reset event", evt, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: level 0x00 never sags
    cycles = 8'h01;
    for (int i = 0; i < 4; i++) begin
      tick(1'b1, 20'h00000, 1'b0);
      tick(1'b0, 20'h0, 1'b1);
    end
    chk("R3 level zero no sag", sag_n, 1);

    // table walk at N = 1
    for (int i = 0; i < 11; i++) begin
      level = VECS[i][8:1];
      clean_start();
      tick(1'b1, VECS[i][28:9], 1'b0);
      tick(1'b0, 20'h0, 1'b1);
      chk($sformatf("R3 vec%0d sag_n", i), sag_n, !VECS[i][0]);
      chk($sformatf("R9 vec%0d event", i), evt, VECS[i][0]);
    end

    // R5: N = 3
    level = 8'h10; cycles = 8'd3;
    clean_start();
    tick(1'b1, 20'h00100, 1'b0);
    tick(1'b0, 20'h0, 1'b1);
    chk("R5 half 1", sag_n, 1);
    tick(1'b1, 20'h00100, 1'b0);
    tick(1'b0, 20'h0, 1'b1);
    chk("R5 half 2", sag_n, 1);
    tick(1'b0, 20'h0, 1'b1);
    chk("R5 half 3 sag_n", sag_n, 0);
    chk("R9 entry event", evt, 1);
    tick(1'b0, 20'h0, 1'b0);
    chk("R9 pulse ends", evt, 0);
    chk("R5 held", sag_n, 0);
    tick(1'b0, 20'h0, 1'b1);
    chk("R9 no repeat", evt, 0);
    chk("R5 still low", sag_n, 0);

    // R7: release then recount
    tick(1'b1, 20'h40000, 1'b0);
    chk("R7 release", sag_n, 1);
    tick(1'b0, 20'h0, 1'b1);
    chk("R4 dirty half not counted", sag_n, 1);
    tick(1'b0, 20'h0, 1'b1);
    tick(1'b0, 20'h0, 1'b1);
    chk("R7 count restarted", sag_n, 1);
    tick(1'b0, 20'h0, 1'b1);
    chk("R7 reassert after 3", sag_n, 0);

    // R4: high sample on the boundary cycle
    cycles = 8'd2;
    clean_start();
    tick(1'b0, 20'h0, 1'b1);
    chk("R4 one half", sag_n, 1);
    tick(1'b1, 20'h7FFFF, 1'b1);
    chk("R4 same-cycle high", sag_n, 1);
    tick(1'b0, 20'h0, 1'b1);
    chk("R4 count from one", sag_n, 1);
    tick(1'b0, 20'h0, 1'b1);
    chk("R4 second clean half", sag_n, 0);

    // R6: N = 0
    cycles = 8'd0;
    clean_start();
    chk("R6 clean", sag_n, 1);
    tick(1'b0, 20'h0, 1'b1);
    chk("R6 zero as one", sag_n, 0);
    chk("R6 event", evt, 1);

    // R8: disable
    cycles = 8'd1; dis = 1'b1;
    clean_start();
    tick(1'b0, 20'h0, 1'b1);
    chk("R8 pin held high", sag_n, 1);
    chk("R8 event independent", evt, 1);
    dis = 1'b0; #1;
    chk("R8 enable drives low", sag_n, 0);
    dis = 1'b1; #1;
    chk("R8 disable releases pin", sag_n, 1);
    dis = 1'b0;
    @(negedge clk);

    // R10: N = 255 and saturation
    cycles = 8'd255;
    clean_start();
    for (int i = 0; i < 254; i++) tick(1'b0, 20'h0, 1'b1);
    chk("R10 after 254", sag_n, 1);
    tick(1'b0, 20'h0, 1'b1);
    chk("R10 after 255", sag_n, 0);
    chk("R10 event", evt, 1);
    for (int i = 0; i < 10; i++) tick(1'b0, 20'h0, 1'b1);
    chk("R10 saturated held", sag_n, 0);
    chk("R9 no event while held", evt, 0);

    // R11: reset during active sag
    rst_n = 1'b0; #1;
    chk("R11 async reset sag_n", sag_n, 1);
    @(negedge clk);
    rst_n = 1'b1; cycles = 8'd2;
    @(negedge clk);
    tick(1'b0, 20'h0, 1'b1);
    chk("R11 count zero after reset", sag_n, 1);
    tick(1'b0, 20'h0, 1'b1);
    chk("R11 counts from zero", sag_n, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule